// File: doc/BRIEF.md
# Ethernet MAC Control and Interrupt Register File

This block is the software-visible register file of a small Ethernet MAC. A 32-bit register port with a word index reaches the interrupt status, the interrupt enable mask, the receive and transmit control words, the transmit start threshold, the 48-bit station address and the management-interface control, divider and data registers. The stored control values drive the datapath and management engine directly through output ports.

The transmit and receive datapaths report events by one-cycle pulses on a 7-bit event input. Each pulse latches a bit in the raw status register. A single level interrupt is raised while any latched bit is also enabled in the mask. Software clears status bits by writing ones to the status offset.

Some writes also produce single-cycle side-band pulses back to the datapaths. Clearing the transmit-error status flushes the transmit buffer. Setting the FIFO-reset bit of receive control resets the receive buffer. A dedicated strobe offset requests a manual transmit. Read data is registered, so it appears one cycle after the access.

Top module: `eth_mac_regs`

## Requirements
- R1: After reset, the mask reads 0x7F, receive control reads 0x08, the management divider reads 0x80, the threshold reads 0x3F, and the status, transmit control, station address, management control and management data registers read 0. The interrupt output is low.
- R2: A 1 on bit b of `evt_i` sets raw status bit b on that clock edge. Index 0 is RX done, 1 is TX error, 2 is TX empty, 3 is FIFO overrun, 4 is RX error, 5 is management done and 6 is PHY. A read of word 0 returns the raw status in bits 6:0.
- R3: `irq_o` is high exactly when some bit is set in both the raw status and the mask. The mask is written and read at word 1, bits 6:0.
- R4: A write to word 0 clears each raw status bit whose data bit is 1 and leaves the others unchanged.
- R5: When an event pulse and a clearing write hit the same status bit on the same edge, the bit ends up set.
- R6: A write to word 0 with data bit 1 set makes `tx_flush_o` high for exactly the one cycle after the write. Other writes to word 0 do not raise it.
- R7: Receive control is stored from bits 4:0 of a write to word 2 and appears on `rx_ctrl_o`. Bit 0 is enable, 1 is accept multicast, 2 is promiscuous, 3 is reject bad CRC and 4 is FIFO reset. When bit 4 of the written data is 1, `rx_reset_o` pulses for the one cycle after the write.
- R8: A write to word 8 stores bits 7:0 as management control with bit 0 (start) forced to 0. Word 11 keeps only bits 7:0 as management transmit data.
- R9: The station address is little-endian. Word 5 holds address bytes 0..3 in bits 31:0, and word 6 holds bytes 4..5 in bits 15:0 with bits 31:16 reading 0. `mac_addr_o[7:0]` is byte 0.
- R10: A write to word 14 with data bit 0 set makes `tx_go_o` high for the one cycle after the write. Word 14 reads as 0.
- R11: Words 4, 10 and 15 read 0. Word 12 reads `mdio_rxd_i` and word 13 reads `rx_frames_i`. Writes to words 4, 10, 12, 13 and 15 change no register.
- R12: Read data appears on `rdata_o` in the cycle after the read access and holds until the next read.
- R13: Transmit control is stored from bits 3:0 of word 3 and drives `tx_ctrl_o`. Bit 0 is enable, 1 is pad, 2 is auto CRC and 3 is full duplex. The threshold is stored from bits 5:0 of word 7 and drives `tx_thresh_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 7 | Status set pulses from the datapaths |
| mdio_rxd_i | input | 8 | Management receive data |
| rx_frames_i | input | 6 | Count of frames held in receive storage |
| irq_o | output | 1 | Level interrupt |
| rx_ctrl_o | output | 5 | Receive control word |
| tx_ctrl_o | output | 4 | Transmit control word |
| tx_thresh_o | output | 6 | Transmit start threshold |
| mac_addr_o | output | 48 | Station address |
| mdio_ctrl_o | output | 8 | Management control |
| mdio_div_o | output | 8 | Management clock divider |
| mdio_txd_o | output | 8 | Management transmit data |
| tx_flush_o | output | 1 | Transmit buffer flush pulse |
| rx_reset_o | output | 1 | Receive buffer reset pulse |
| tx_go_o | output | 1 | Manual transmit pulse |

## Verification
The assertions assume that `evt_i` and the register strobes are driven by the same clock and are inactive during reset. They also assume that a status bit pulsed on `evt_i` is not expected to stay cleared when a write clears it on that same edge. The stimulus changes every input only on the falling edge and holds `req_i` and `evt_i` low through reset. Event and clear collisions are issued on purpose only in the one case that exercises the set-priority rule.

// File: rtl/emr_pkg.sv
package emr_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 4;
  localparam int unsigned IRQ_W = 7;
  localparam int unsigned RXC_W = 5;
  localparam int unsigned TXC_W = 4;
  localparam int unsigned THR_W = 6;
  localparam int unsigned MD_W  = 8;
  localparam int unsigned FRM_W = 6;
  localparam int unsigned MAC_W = 48;
  localparam int unsigned LO_W  = 32;
  localparam int unsigned HI_W  = MAC_W - LO_W;

  localparam int unsigned IRQ_TXER_BIT = 1;
  localparam int unsigned RXC_RST_BIT  = 4;
  localparam int unsigned MCTL_GO_BIT  = 0;
  localparam int unsigned TXGO_BIT     = 0;

  localparam logic [IRQ_W-1:0] MASK_RST = 7'h7f;
  localparam logic [RXC_W-1:0] RXC_RST  = 5'h08;
  localparam logic [THR_W-1:0] THR_RST  = 6'h3f;
  localparam logic [MD_W-1:0]  MDIV_RST = 8'h80;

  typedef enum logic [AW-1:0] {
    W_STAT  = 4'd0,  W_MASK  = 4'd1,  W_RXC   = 4'd2,  W_TXC  = 4'd3,
    W_DATA  = 4'd4,  W_ADRLO = 4'd5,  W_ADRHI = 4'd6,  W_THR  = 4'd7,
    W_MCTL  = 4'd8,  W_MDIV  = 4'd9,  W_MPHY  = 4'd10, W_MTXD = 4'd11,
    W_MRXD  = 4'd12, W_NFRM  = 4'd13, W_TXGO  = 4'd14, W_TSTP = 4'd15
  } reg_ofs_e;
endpackage

// File: rtl/emr_irq_unit.sv
module emr_irq_unit
  import emr_pkg::*;
#(
  parameter int unsigned N = IRQ_W,
  parameter logic [N-1:0] MASK_INIT = MASK_RST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] ris_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] ris_q, mask_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    // set beats clear so a colliding event survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ris_q[b] <= 1'b0;
      else if (set_i[b])    ris_q[b] <= 1'b1;
      else if (clr_i[b])    ris_q[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= MASK_INIT;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  assign ris_o  = ris_q;
  assign mask_o = mask_q;
  assign irq_o  = |(ris_q & mask_q);
endmodule

// File: rtl/emr_cfg_bank.sv
module emr_cfg_bank
  import emr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    ofs_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [RXC_W-1:0] rxc_o,
  output logic [TXC_W-1:0] txc_o,
  output logic [THR_W-1:0] thr_o,
  output logic [MAC_W-1:0] mac_o,
  output logic [MD_W-1:0]  mctl_o,
  output logic [MD_W-1:0]  mdiv_o,
  output logic [MD_W-1:0]  mtxd_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  logic [MD_W-1:0] mctl_d;
  always_comb begin
    mctl_d = wdata_i[MD_W-1:0];
    mctl_d[MCTL_GO_BIT] = 1'b0;   // start completes at once
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxc_o  <= RXC_RST;
      txc_o  <= '0;
      thr_o  <= THR_RST;
      mac_o  <= '0;
      mctl_o <= '0;
      mdiv_o <= MDIV_RST;
      mtxd_o <= '0;
    end else if (we_i) begin
      case (reg_ofs_e'(ofs_i))
        W_RXC:   rxc_o  <= wdata_i[RXC_W-1:0];
        W_TXC:   txc_o  <= wdata_i[TXC_W-1:0];
        W_THR:   thr_o  <= wdata_i[THR_W-1:0];
        W_ADRLO: mac_o[LO_W-1:0]     <= wdata_i[LO_W-1:0];
        W_ADRHI: mac_o[MAC_W-1:LO_W] <= wdata_i[HI_W-1:0];
        W_MCTL:  mctl_o <= mctl_d;
        W_MDIV:  mdiv_o <= wdata_i[MD_W-1:0];
        W_MTXD:  mtxd_o <= wdata_i[MD_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eth_mac_regs.sv
module eth_mac_regs
  import emr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [IRQ_W-1:0] evt_i,
  input  logic [MD_W-1:0]  mdio_rxd_i,
  input  logic [FRM_W-1:0] rx_frames_i,
  output logic             irq_o,
  output logic [RXC_W-1:0] rx_ctrl_o,
  output logic [TXC_W-1:0] tx_ctrl_o,
  output logic [THR_W-1:0] tx_thresh_o,
  output logic [MAC_W-1:0] mac_addr_o,
  output logic [MD_W-1:0]  mdio_ctrl_o,
  output logic [MD_W-1:0]  mdio_div_o,
  output logic [MD_W-1:0]  mdio_txd_o,
  output logic             tx_flush_o,
  output logic             rx_reset_o,
  output logic             tx_go_o
);
  logic wr, rd;
  reg_ofs_e ofs;
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;
  assign ofs = reg_ofs_e'(addr_i);

  logic [IRQ_W-1:0] ris, mask, ack_clr;
  assign ack_clr = (wr && ofs == W_STAT) ? wdata_i[IRQ_W-1:0] : '0;

  emr_irq_unit #(.N(IRQ_W), .MASK_INIT(MASK_RST)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (evt_i),
    .clr_i     (ack_clr),
    .mask_we_i (wr && ofs == W_MASK),
    .mask_d_i  (wdata_i[IRQ_W-1:0]),
    .ris_o     (ris),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  emr_cfg_bank u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr),
    .ofs_i   (addr_i),
    .wdata_i (wdata_i),
    .rxc_o   (rx_ctrl_o),
    .txc_o   (tx_ctrl_o),
    .thr_o   (tx_thresh_o),
    .mac_o   (mac_addr_o),
    .mctl_o  (mdio_ctrl_o),
    .mdiv_o  (mdio_div_o),
    .mtxd_o  (mdio_txd_o)
  );

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (ofs)
      W_STAT:  rd_mux[IRQ_W-1:0] = ris;
      W_MASK:  rd_mux[IRQ_W-1:0] = mask;
      W_RXC:   rd_mux[RXC_W-1:0] = rx_ctrl_o;
      W_TXC:   rd_mux[TXC_W-1:0] = tx_ctrl_o;
      W_ADRLO: rd_mux[LO_W-1:0]  = mac_addr_o[LO_W-1:0];
      W_ADRHI: rd_mux[HI_W-1:0]  = mac_addr_o[MAC_W-1:LO_W];
      W_THR:   rd_mux[THR_W-1:0] = tx_thresh_o;
      W_MCTL:  rd_mux[MD_W-1:0]  = mdio_ctrl_o;
      W_MDIV:  rd_mux[MD_W-1:0]  = mdio_div_o;
      W_MTXD:  rd_mux[MD_W-1:0]  = mdio_txd_o;
      W_MRXD:  rd_mux[MD_W-1:0]  = mdio_rxd_i;
      W_NFRM:  rd_mux[FRM_W-1:0] = rx_frames_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      tx_flush_o <= 1'b0;
      rx_reset_o <= 1'b0;
      tx_go_o    <= 1'b0;
    end else begin
      if (rd) rdata_o <= rd_mux;
      tx_flush_o <= wr && ofs == W_STAT && wdata_i[IRQ_TXER_BIT];
      rx_reset_o <= wr && ofs == W_RXC  && wdata_i[RXC_RST_BIT];
      tx_go_o    <= wr && ofs == W_TXGO && wdata_i[TXGO_BIT];
    end
  end
endmodule

// File: rtl/emr_checker.sv
module emr_checker
  import emr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [IRQ_W-1:0] evt_i,
  input logic             irq_o,
  input logic             tx_flush_o,
  input logic             rx_reset_o,
  input logic             tx_go_o,
  input logic [IRQ_W-1:0] ris_q,
  input logic [IRQ_W-1:0] mask_q
);
  // R2
  evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((ris_q & $past(evt_i)) == $past(evt_i)));

  // R3
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ris_q & mask_q) == '0) |-> !irq_o);

  // R4
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(W_STAT) && evt_i == '0)
      |=> ((ris_q & $past(wdata_i[IRQ_W-1:0])) == '0));

  // R6
  flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |-> $past(req_i && we_i && addr_i == AW'(W_STAT) && wdata_i[IRQ_TXER_BIT]));

  // R7
  rxrst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_o |-> $past(req_i && we_i && addr_i == AW'(W_RXC) && wdata_i[RXC_RST_BIT]));

  // R10
  txgo_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_go_o |-> $past(req_i && we_i && addr_i == AW'(W_TXGO) && wdata_i[TXGO_BIT]));
endmodule

bind eth_mac_regs emr_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .evt_i      (evt_i),
  .irq_o      (irq_o),
  .tx_flush_o (tx_flush_o),
  .rx_reset_o (rx_reset_o),
  .tx_go_o    (tx_go_o),
  .ris_q      (ris),
  .mask_q     (mask)
);

// File: tb/tb_eth_mac_regs.sv
module tb_eth_mac_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  evt_i = '0;
  logic [7:0]  mdio_rxd_i = 8'h5a;
  logic [5:0]  rx_frames_i = 6'd3;
  logic        irq_o, tx_flush_o, rx_reset_o, tx_go_o;
  logic [4:0]  rx_ctrl_o;
  logic [3:0]  tx_ctrl_o;
  logic [5:0]  tx_thresh_o;
  logic [47:0] mac_addr_o;
  logic [7:0]  mdio_ctrl_o, mdio_div_o, mdio_txd_o;

  always #10 clk_i = ~clk_i;

  eth_mac_regs dut (.*);

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int total = 0, bad = 0;
  logic p_flush, p_rrst, p_go;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data one cycle after the access
  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      chk(rdata_o == it.exp, it.tag, 64'(rdata_o), 64'(it.exp));
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i);
    sb_q.push_back('{exp, tag});
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [6:0] ev);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; evt_i = ev;
    @(posedge clk_i);
    @(negedge clk_i);
    p_flush = tx_flush_o; p_rrst = rx_reset_o; p_go = tx_go_o;
    req_i = 0; we_i = 0; evt_i = '0;
  endtask

  task automatic ev(input logic [6:0] b);
    @(negedge clk_i); evt_i = b;
    @(negedge clk_i); evt_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    rd(4'd1, 32'h7f, "R1 mask");
    rd(4'd2, 32'h08, "R1 rxc");
    rd(4'd9, 32'h80, "R1 mdiv");
    rd(4'd7, 32'h3f, "R1 thr");
    rd(4'd0, 32'h00, "R1 stat");
    rd(4'd3, 32'h00, "R1 txc");
    rd(4'd5, 32'h00, "R1 adrlo");
    rd(4'd8, 32'h00, "R1 mctl");
    chk(irq_o == 0, "R1 irq", 64'(irq_o), 0);
    // R2 status latch, R3 irq
    ev(7'h05);
    rd(4'd0, 32'h05, "R2 stat");
    chk(irq_o == 1, "R3 irq on", 64'(irq_o), 1);
    wr(4'd1, 32'h0, 7'h0);
    chk(irq_o == 0, "R3 masked", 64'(irq_o), 0);
    wr(4'd1, 32'h04, 7'h0);
    chk(irq_o == 1, "R3 one bit", 64'(irq_o), 1);
    rd(4'd1, 32'h04, "R3 mask rb");
    wr(4'd1, 32'h7f, 7'h0);
    ev(7'h40);
    rd(4'd0, 32'h45, "R2 phy");
    // R4 write-one-to-clear
    wr(4'd0, 32'h41, 7'h0);
    rd(4'd0, 32'h04, "R4 partial");
    chk(p_flush == 0, "R6 no flush", 64'(p_flush), 0);
    wr(4'd0, 32'h04, 7'h0);
    chk(irq_o == 0, "R4 irq off", 64'(irq_o), 0);
    rd(4'd0, 32'h00, "R4 empty");
    // R5 set wins
    wr(4'd0, 32'h01, 7'h01);
    rd(4'd0, 32'h01, "R5 set wins");
    wr(4'd0, 32'h01, 7'h0);
    // R6 flush pulse
    ev(7'h02);
    wr(4'd0, 32'h02, 7'h0);
    chk(p_flush == 1, "R6 flush", 64'(p_flush), 1);
    @(negedge clk_i);
    chk(tx_flush_o == 0, "R6 one cycle", 64'(tx_flush_o), 0);
    rd(4'd0, 32'h00, "R6 cleared");
    // R7 rx control
    wr(4'd2, 32'hffff_ff13, 7'h0);
    chk(p_rrst == 1, "R7 rx reset", 64'(p_rrst), 1);
    chk(rx_ctrl_o == 5'h13, "R7 rx_ctrl_o", 64'(rx_ctrl_o), 64'h13);
    rd(4'd2, 32'h13, "R7 rxc rb");
    wr(4'd2, 32'h01, 7'h0);
    chk(p_rrst == 0, "R7 no reset", 64'(p_rrst), 0);
    // R8 management
    wr(4'd8, 32'h1a5, 7'h0);
    rd(4'd8, 32'ha4, "R8 start clr");
    wr(4'd11, 32'h1234, 7'h0);
    rd(4'd11, 32'h34, "R8 txd");
    chk(mdio_txd_o == 8'h34, "R8 txd port", 64'(mdio_txd_o), 64'h34);
    // R9 station address
    wr(4'd5, 32'h4433_2211, 7'h0);
    wr(4'd6, 32'hffff_6655, 7'h0);
    chk(mac_addr_o == 48'h6655_4433_2211, "R9 mac", 64'(mac_addr_o), 64'h665544332211);
    rd(4'd6, 32'h6655, "R9 hi");
    rd(4'd5, 32'h4433_2211, "R9 lo");
    // R10 manual transmit
    wr(4'd14, 32'h1, 7'h0);
    chk(p_go == 1, "R10 go", 64'(p_go), 1);
    wr(4'd14, 32'h2, 7'h0);
    chk(p_go == 0, "R10 no go", 64'(p_go), 0);
    rd(4'd14, 32'h0, "R10 reads 0");
    // R11 ignored and read-only offsets
    wr(4'd10, 32'hffff_ffff, 7'h0);
    wr(4'd15, 32'hffff_ffff, 7'h0);
    wr(4'd12, 32'hffff_ffff, 7'h0);
    wr(4'd13, 32'hffff_ffff, 7'h0);
    wr(4'd4,  32'hffff_ffff, 7'h0);
    rd(4'd10, 32'h0, "R11 madd");
    rd(4'd15, 32'h0, "R11 tstp");
    rd(4'd4,  32'h0, "R11 data");
    rd(4'd12, 32'h5a, "R11 mrxd");
    rd(4'd13, 32'h03, "R11 nfrm");
    rd(4'd0,  32'h00, "R11 stat kept");
    rd(4'd1,  32'h7f, "R11 mask kept");
    rd(4'd2,  32'h01, "R11 rxc kept");
    rd(4'd9,  32'h80, "R11 mdiv kept");
    rd(4'd8,  32'ha4, "R11 mctl kept");
    // R13 tx control and threshold
    wr(4'd3, 32'hff, 7'h0);
    chk(tx_ctrl_o == 4'hf, "R13 txc", 64'(tx_ctrl_o), 64'hf);
    wr(4'd7, 32'h52, 7'h0);
    chk(tx_thresh_o == 6'h12, "R13 thr", 64'(tx_thresh_o), 64'h12);
    rd(4'd7, 32'h12, "R13 thr rb");
    // R12 read data holds
    rd(4'd3, 32'hf, "R12 txc");
    repeat (3) @(negedge clk_i);
    chk(rdata_o == 32'hf, "R12 hold", 64'(rdata_o), 64'hf);
    repeat (2) @(negedge clk_i);
    chk(sb_q.size() == 0, "R12 drained", 64'(sb_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule